// File: doc/BRIEF.md
# Multi-Channel DAC Data and Trim Register Bank

This block keeps the digital state behind a 40-channel, 14-bit voltage DAC. The channels form five groups of eight (group g owns channels 8g to 8g+7). Every channel stores two input words (A and B), a gain trim and an offset trim. From these it derives two calibrated words. A per-group select register picks, for each channel, which calibrated word the final DAC register takes. All final DAC registers load together on a single-cycle load strobe.

A single write port carries a type select, an address and 14-bit data. A combinational read port returns every stored register. The calibrated words and the final DAC registers are not directly accessible. Their only effect is on the DAC output bus.

The bank also holds a 3-bit control register and three offset-DAC words. The control register steers input writes and drives the power-down and thermal-shutdown enable outputs. The offset-DAC words are fanned out per group.

Top module: `dac_bank_regs`

## Requirements
- R1: After synchronous reset, the registers hold the following values. Input A and input B read 0x1555. Gain reads 0x3FFF and offset trim reads 0x2000. Each offset-DAC word reads 0x1555. Control and all select registers read 0. Every DAC output word is 0x1555.
- R2: The type code selects the register. Type 0 is input data, type 1 is gain trim, type 2 is offset trim and type 3 is global. For types 0 to 2 the address is the channel number. A type-0 write lands in input A when control bit 2 is 0 and in input B when it is 1. A type-0 read returns the register chosen by the same bit.
- R3: A type 0 to 2 write to a channel number of 40 or more changes nothing. The matching read returns 0 with rd_err high.
- R4: Each calibrated word equals floor(in*(gain+1)/16384) + offset − 0x2000, saturated to the range 0 to 0x3FFF.
- R5: A calibrated word reflects a write when a load strobe is sampled two or more clock edges after the write edge.
- R6: Global addresses 8 to 12 hold the select registers of groups 0 to 4. Bit b of group g's register picks the source for channel 8g+b: 0 selects calibrated A, 1 selects calibrated B.
- R7: The DAC output words change only on a clock edge where load is high, and all 40 words update on that edge.
- R8: Global addresses 0, 1 and 2 hold the three offset-DAC words. grp_ofs word g carries word g for groups 0 and 1. Groups 2, 3 and 4 all carry word 2.
- R9: Global address 3 is the control register. Bit 0 drives pwr_down and bit 1 drives tsd_en. Both follow the register from the edge after the write. Power-down keeps all register and DAC contents.
- R10: The read port returns 0 with rd_err high for any unmapped global address. A read of a mapped register has rd_err low.
- R11: A write to an unmapped global address (4 to 7, or 13 and above) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_typ | input | 2 | Write register type |
| wr_addr | input | 6 | Write channel or global address |
| wr_data | input | 14 | Write data |
| rd_typ | input | 2 | Read register type |
| rd_addr | input | 6 | Read channel or global address |
| rd_data | output | 14 | Read data (combinational) |
| rd_err | output | 1 | Read of an unmapped location |
| load | input | 1 | Load all final DAC registers |
| dac_out | output | 560 | Final DAC words, channel c at bits 14c+13:14c |
| grp_ofs | output | 70 | Offset-DAC word per group, group g at bits 14g+13:14g |
| tsd_en | output | 1 | Thermal shutdown enable |
| pwr_down | output | 1 | Software power-down status |

## Verification
The hardest state to reach is a channel whose final word comes from calibrated B while ordinary writes keep landing in A. This needs a steering change in the control register and a select bit set in the right group before a load. The calibration result must also sit at a clamp. Directed steps drive each saturation end with extreme gain and offset trims. Random stimulus then toggles control bit 2, writes select registers and interleaves loads. The loads are always preceded by two idle cycles, so every channel's A/B choice is compared against a bench model.

// File: rtl/dac_bank_regs.sv
module dac_bank_regs #(
  parameter int W    = 14,
  parameter int NGRP = 5,
  parameter int GRP  = 8,
  parameter int NOFS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_typ,
  input  logic [5:0]           wr_addr,
  input  logic [W-1:0]         wr_data,
  input  logic [1:0]           rd_typ,
  input  logic [5:0]           rd_addr,
  output logic [W-1:0]         rd_data,
  output logic                 rd_err,
  input  logic                 load,
  output logic [NGRP*GRP*W-1:0] dac_out,
  output logic [NGRP*W-1:0]    grp_ofs,
  output logic                 tsd_en,
  output logic                 pwr_down
);
  localparam int NCH = NGRP * GRP;
  localparam logic [W-1:0] IN_RST  = W'(16'h1555);
  localparam logic [W-1:0] G_RST   = {W{1'b1}};
  localparam logic [W-1:0] MID     = W'(1) << (W-1);
  localparam logic [5:0]   A_CTL   = 6'd3;
  localparam logic [5:0]   A_SEL   = 6'd8;

  logic [W-1:0]   in_a [NCH];
  logic [W-1:0]   in_b [NCH];
  logic [W-1:0]   gain [NCH];
  logic [W-1:0]   offs [NCH];
  logic [W-1:0]   cal_a [NCH];
  logic [W-1:0]   cal_b [NCH];
  logic [W-1:0]   dac [NCH];
  logic [W-1:0]   ofs [NOFS];
  logic [GRP-1:0] sel [NGRP];
  logic [2:0]     ctl;
  logic           pend;
  logic [5:0]     pend_ch;

  function automatic logic [W-1:0] calib(input logic [W-1:0] x, input logic [W-1:0] g,
                                         input logic [W-1:0] o);
    logic [2*W:0]        p;
    logic signed [W+2:0] s;
    p = (2*W+1)'(x) * (2*W+1)'(g) + (2*W+1)'(x);
    s = $signed({2'b00, p[2*W:W]}) + $signed({3'b000, o}) - $signed({3'b000, MID});
    if (s < 0)                                 calib = '0;
    else if (s > $signed({3'b000, G_RST}))     calib = G_RST;
    else                                       calib = s[W-1:0];
  endfunction

  localparam logic [W-1:0] CAL_RST = calib(IN_RST, G_RST, MID);

  wire ch_wr = wr_en && wr_typ != 2'd3 && wr_addr < 6'(NCH);
  wire gl_wr = wr_en && wr_typ == 2'd3;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        in_a[c] <= IN_RST; in_b[c] <= IN_RST; gain[c] <= G_RST; offs[c] <= MID;
        cal_a[c] <= CAL_RST; cal_b[c] <= CAL_RST; dac[c] <= CAL_RST;
      end
      for (int k = 0; k < NOFS; k++) ofs[k] <= IN_RST;
      for (int g = 0; g < NGRP; g++) sel[g] <= '0;
      ctl <= '0;
      pend <= 1'b0;
      pend_ch <= '0;
    end else begin
      pend <= ch_wr;
      pend_ch <= wr_addr;
      if (ch_wr) begin
        case (wr_typ)
          2'd0:    if (ctl[2]) in_b[wr_addr] <= wr_data; else in_a[wr_addr] <= wr_data;
          2'd1:    gain[wr_addr] <= wr_data;
          default: offs[wr_addr] <= wr_data;
        endcase
      end
      if (gl_wr) begin
        if (wr_addr < 6'(NOFS)) ofs[wr_addr] <= wr_data;
        else if (wr_addr == A_CTL) ctl <= wr_data[2:0];
        else if (wr_addr >= A_SEL && wr_addr < A_SEL + 6'(NGRP))
          sel[wr_addr - A_SEL] <= wr_data[GRP-1:0];
      end
      if (pend) begin
        cal_a[pend_ch] <= calib(in_a[pend_ch], gain[pend_ch], offs[pend_ch]);
        cal_b[pend_ch] <= calib(in_b[pend_ch], gain[pend_ch], offs[pend_ch]);
      end
      if (load)
        for (int c = 0; c < NCH; c++)
          dac[c] <= sel[c / GRP][c % GRP] ? cal_b[c] : cal_a[c];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    if (rd_typ != 2'd3) begin
      if (rd_addr < 6'(NCH)) begin
        case (rd_typ)
          2'd0:    rd_data = ctl[2] ? in_b[rd_addr] : in_a[rd_addr];
          2'd1:    rd_data = gain[rd_addr];
          default: rd_data = offs[rd_addr];
        endcase
      end else rd_err = 1'b1;
    end else if (rd_addr < 6'(NOFS)) rd_data = ofs[rd_addr];
    else if (rd_addr == A_CTL) rd_data = W'(ctl);
    else if (rd_addr >= A_SEL && rd_addr < A_SEL + 6'(NGRP)) rd_data = W'(sel[rd_addr - A_SEL]);
    else rd_err = 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dac
    assign dac_out[c*W +: W] = dac[c];
  end
  for (genvar g = 0; g < NGRP; g++) begin : g_ofs
    assign grp_ofs[g*W +: W] = ofs[(g < NOFS - 1) ? g : NOFS - 1];
  end

  assign pwr_down = ctl[0];
  assign tsd_en   = ctl[1];
endmodule

module dac_bank_regs_chk #(
  parameter int W    = 14,
  parameter int NGRP = 5,
  parameter int GRP  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_typ,
  input logic [5:0]             wr_addr,
  input logic [W-1:0]           wr_data,
  input logic [W-1:0]           rd_data,
  input logic                   rd_err,
  input logic                   load,
  input logic [NGRP*GRP*W-1:0]  dac_out,
  input logic [NGRP*W-1:0]      grp_ofs,
  input logic                   tsd_en,
  input logic                   pwr_down
);
  wire ctl_wr = wr_en && wr_typ == 2'd3 && wr_addr == 6'd3;

  a_r7_dac_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dac_out));
  a_r9_ctl_follow: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (pwr_down == $past(wr_data[0]) && tsd_en == $past(wr_data[1])));
  a_r9_pd_keep: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(pwr_down) && $stable(tsd_en)));
  a_r11_ofs_keep: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_typ == 2'd3) |=> $stable(grp_ofs));
  a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rd_data == '0);
endmodule

bind dac_bank_regs dac_bank_regs_chk #(.W(W), .NGRP(NGRP), .GRP(GRP)) u_chk (.*);

// File: tb/tb_dac_bank_regs.sv
module tb_dac_bank_regs;
  localparam int NCH = 40;
  logic clk = 0, rst = 1, wr_en = 0, load = 0;
  logic [1:0] wr_typ = 0, rd_typ = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [13:0] wr_data = 0;
  logic [13:0] rd_data;
  logic rd_err, tsd_en, pwr_down;
  logic [NCH*14-1:0] dac_out;
  logic [5*14-1:0] grp_ofs;

  dac_bank_regs dut (.*);
  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int ma[NCH], mb[NCH], mg[NCH], mo[NCH], mdac[NCH], mofs[3], msel[5];
  int mctl;

  function automatic int cal(int x, int g, int o);
    int v = ((x * (g + 1)) >>> 14) + o - 8192;
    return v < 0 ? 0 : (v > 16383 ? 16383 : v);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(int t, int a, output int d, output bit e);
    d = 0; e = 0;
    if (t != 3) begin
      if (a >= NCH) e = 1;
      else d = t == 0 ? (mctl[2] ? mb[a] : ma[a]) : (t == 1 ? mg[a] : mo[a]);
    end else if (a < 3) d = mofs[a];
    else if (a == 3) d = mctl;
    else if (a >= 8 && a < 13) d = msel[a-8];
    else e = 1;
  endtask

  task automatic rd_chk(int t, int a, string tag);
    int d; bit e;
    exp_rd(t, a, d, e);
    @(negedge clk);
    rd_typ = 2'(t); rd_addr = 6'(a);
    #1;
    chk(rd_data == 14'(d) && rd_err == e, tag, {rd_err, rd_data}, {e, 14'(d)});
  endtask

  task automatic wr(int t, int a, int d);
    @(negedge clk);
    wr_en = 1; wr_typ = 2'(t); wr_addr = 6'(a); wr_data = 14'(d);
    @(negedge clk);
    wr_en = 0;
    if (t == 0 && a < NCH) begin if (mctl[2]) mb[a] = d; else ma[a] = d; end
    else if (t == 1 && a < NCH) mg[a] = d;
    else if (t == 2 && a < NCH) mo[a] = d;
    else if (t == 3) begin
      if (a < 3) mofs[a] = d;
      else if (a == 3) mctl = d & 7;
      else if (a >= 8 && a < 13) msel[a-8] = d & 255;
    end
  endtask

  task automatic dac_chk(string tag);
    for (int c = 0; c < NCH; c++)
      chk(dac_out[c*14 +: 14] == 14'(mdac[c]), tag, int'(dac_out[c*14 +: 14]), mdac[c]);
  endtask

  task automatic do_load();
    @(negedge clk); @(negedge clk);
    dac_chk("R7 hold before load");
    load = 1;
    @(negedge clk);
    load = 0;
    for (int c = 0; c < NCH; c++)
      mdac[c] = msel[c/8][c%8] ? cal(mb[c], mg[c], mo[c]) : cal(ma[c], mg[c], mo[c]);
    dac_chk("R4 R5 R6 R7 load");
  endtask

  task automatic side_chk();
    chk(pwr_down == mctl[0] && tsd_en == mctl[1], "R9 ctl outputs",
        {tsd_en, pwr_down}, mctl & 3);
    for (int g = 0; g < 5; g++)
      chk(grp_ofs[g*14 +: 14] == 14'(mofs[g < 2 ? g : 2]), "R8 group offset",
          int'(grp_ofs[g*14 +: 14]), mofs[g < 2 ? g : 2]);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin
      ma[c] = 'h1555; mb[c] = 'h1555; mg[c] = 'h3FFF; mo[c] = 'h2000; mdac[c] = 'h1555;
    end
    for (int k = 0; k < 3; k++) mofs[k] = 'h1555;
    for (int g = 0; g < 5; g++) msel[g] = 0;
    mctl = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_chk(0, 0, "R1 input A");
    rd_chk(1, 39, "R1 gain");
    rd_chk(2, 17, "R1 offset trim");
    rd_chk(3, 2, "R1 ofs word");
    rd_chk(3, 3, "R1 control");
    rd_chk(3, 12, "R1 select");
    dac_chk("R1 dac reset");
    side_chk();
    // R2 steering
    wr(0, 5, 'h0123);
    rd_chk(0, 5, "R2 A write");
    wr(3, 3, 4);
    rd_chk(0, 5, "R2 B default");
    wr(0, 5, 'h3210);
    rd_chk(0, 5, "R2 B write");
    wr(3, 3, 0);
    rd_chk(0, 5, "R2 A kept");
    // R3 out of range
    wr(1, 40, 7);
    rd_chk(1, 40, "R3 read error");
    rd_chk(1, 39, "R3 no alias");
    // R4 clamps, R6 select B
    wr(1, 0, 0); wr(0, 0, 'h3FFF);
    wr(0, 1, 'h3FFF); wr(2, 1, 'h3FFF);
    wr(2, 2, 0); wr(0, 2, 'h0100);
    wr(3, 8, 'h20);
    wr(3, 13, 'h55);  // R11 unmapped
    wr(3, 6, 'h55);
    do_load();
    rd_chk(3, 13, "R10 unmapped read");
    rd_chk(3, 6, "R10 unmapped read");
    rd_chk(3, 8, "R6 select read");
    // R9 power-down keeps contents
    wr(3, 3, 3);
    side_chk();
    rd_chk(0, 1, "R9 data kept");
    dac_chk("R9 dac kept");
    wr(3, 3, 0);
    // R8 offsets
    wr(3, 0, 'h0AAA); wr(3, 2, 'h3333);
    side_chk();
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 10;
      if (r < 6) begin
        int t = $urandom % 4;
        int a = t == 3 ? $urandom % 16 : $urandom % 44;
        wr(t, a, $urandom % 16384);
        if (t == 3) side_chk();
      end else if (r < 8) begin
        int t = $urandom % 4;
        rd_chk(t, t == 3 ? $urandom % 16 : $urandom % 44, "R2 R3 R10 R11 random read");
      end else if (r == 8) do_load();
      else @(negedge clk);
    end
    do_load();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule